// File: doc/BRIEF.md
# Power-of-Two Converter Clock Prescaler

This block derives a slower converter clock from one of two source clocks. Each source appears as a one-cycle tick strobe in the block's own clock domain. One select input picks which strobe drives the divider, so switching sources is a synchronous choice. A single 32-bit register holds an 8-bit divisor code. The code is one-hot: an all-zero code passes the source through at full rate, and a code with only bit k set divides the source by 2^(k+1). The ratios therefore run from 1 to 256 in powers of two.

The block has two outputs. `div_clk` is the divided clock level, and its duty cycle is 50% for every ratio of 2 or more. `div_pulse` is a one-cycle strobe that fires once per divided period, on the source tick that ends the period.

A code with more than one bit set is not used as a divisor. It is still stored so that software reads back what it wrote. The divider keeps running at the last valid ratio, and a sticky error flag goes high. A new valid ratio waits until the current divided period ends, so no output period is ever cut short.

Top module: `conv_clk_prescaler`

## Requirements
- R1: After reset the divisor code reads back as 0, `code_err` is 0, and the divider runs in bypass (`div_pulse` high on every selected source tick).
- R2: With code 0, `div_pulse` and `div_clk` both follow the selected source tick on every cycle.
- R3: With only bit k of the code set (k = 0..7), `div_pulse` fires exactly once per 2^(k+1) selected source ticks.
- R4: For every ratio of 2 or more, `div_clk` is low for the first half of the source ticks in each divided period and high for the second half.
- R5: A write of a code with two or more bits set stores the code for read-back, sets `code_err` on the next cycle, and leaves the ratio in use unchanged.
- R6: `code_err` stays high through later valid writes and is cleared only by reset.
- R7: Register bits 31:8 always read as zero, and the values written to them have no effect.
- R8: The register answers only at byte offset 0x48. Writes to any other offset change nothing, and reads from other offsets return zero.
- R9: A newly written valid code takes effect only after the divided period in progress completes, at the source tick that raises `div_pulse`.
- R10: The divider counts only ticks of the source chosen by `src_sel` (0 = oscillator tick, 1 = bus-clock tick). Ticks on the other source do not advance it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| src_sel | input | 1 | Source select: 0 = oscillator, 1 = bus clock |
| osc_tick | input | 1 | One-cycle tick per oscillator-source edge |
| bus_tick | input | 1 | One-cycle tick per bus-source edge |
| div_clk | output | 1 | Divided clock level |
| div_pulse | output | 1 | One-cycle strobe at the end of each divided period |
| code_err | output | 1 | Sticky flag for a multi-bit divisor code |

## Verification
Every legal code from bypass to divide-by-256 is run against a source that ticks on every cycle. Over a fixed 512-cycle window the bench counts both the pulses and the high cycles of `div_clk`, so a wrong ratio, a shifted decode, or a lost duty cycle each give a different count. Multi-bit codes, writes that set the reserved bits, and writes to another offset are each followed by a read-back and a pulse count, which separates a wrongly stored code from a wrongly used one. A switch from divide-by-256 to bypass in the middle of a period shows whether the old period is finished first. A sparse bus-clock tick pattern, and a silent one, show that only the selected source advances the counter.

// File: rtl/conv_clk_prescaler.sv
module conv_clk_prescaler #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              src_sel,
  input  logic              osc_tick,
  input  logic              bus_tick,
  output logic              div_clk,
  output logic              div_pulse,
  output logic              code_err
);
  localparam int PAD_W = DATA_W - DIV_W;
  localparam logic [DIV_W-1:0] ONE = 1;
  localparam logic [DIV_W:0] ONE_X = 1;

  logic [DIV_W-1:0] code_q, pend_mask, act_mask, cnt;
  logic [DIV_W-1:0] wr_code, wr_mask;
  logic div_clk_q, err_q;

  wire src_tick = src_sel ? bus_tick : osc_tick;
  wire hit = (reg_addr == REG_OFFSET);
  wire wr_hit = reg_we && hit;
  assign wr_code = reg_wdata[DIV_W-1:0];
  wire wr_multi = |(wr_code & (wr_code - ONE));
  assign wr_mask = (wr_code == '0) ? '0 : (wr_code | (wr_code - ONE));

  wire wrap = src_tick && (cnt == act_mask);
  wire mid = src_tick && (act_mask != '0) && (cnt == (act_mask >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pend_mask <= '0;
      err_q <= 1'b0;
    end else if (wr_hit) begin
      code_q <= wr_code;
      if (wr_multi) err_q <= 1'b1;
      else pend_mask <= wr_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mask <= '0;
      cnt <= '0;
      div_clk_q <= 1'b0;
    end else if (wrap) begin
      act_mask <= pend_mask;
      cnt <= '0;
      div_clk_q <= 1'b0;
    end else if (src_tick) begin
      cnt <= cnt + ONE;
      if (mid) div_clk_q <= 1'b1;
    end
  end

  assign div_pulse = wrap;
  assign div_clk = (act_mask == '0) ? src_tick : div_clk_q;
  assign code_err = err_q;
  assign reg_rdata = hit ? {{PAD_W{1'b0}}, code_q} : '0;

  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_mask));

  // R3
  act_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({1'b0, act_mask} + ONE_X));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_mask);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_tick |=> $stable(cnt) && $stable(div_clk_q));

  // R5
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_multi) |=> (err_q && $stable(pend_mask)));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: tb/test_conv_clk_prescaler.sv
module test_conv_clk_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  localparam int WIN = 512;
  localparam int VEC_CODE [NVEC] = '{0, 1, 2, 4, 8, 16, 32, 64, 128};
  localparam int VEC_RATIO[NVEC] = '{1, 2, 4, 8, 16, 32, 64, 128, 256};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h48;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic src_sel = 1'b0;
  logic osc_tick = 1'b1;
  logic bus_tick = 1'b0;
  logic div_clk, div_pulse, code_err;

  int n_cmp = 0;
  int n_bad = 0;

  conv_clk_prescaler i_conv_clk_prescaler (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_sel(src_sel),
    .osc_tick(osc_tick), .bus_tick(bus_tick), .div_clk(div_clk),
    .div_pulse(div_pulse), .code_err(code_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h48;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 8'h48;
  endtask

  task automatic sync_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic count_win(int len, output int np, output int nh);
    np = 0; nh = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (div_pulse) np++;
      if (div_clk) nh++;
    end
  endtask

  initial begin
    logic [31:0] d;
    int np, nh;
    logic dc0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h48, d);
    check("R1 readback", int'(d), 0);
    check("R1 err", int'(code_err), 0);
    count_win(8, np, nh);
    check("R1 bypass pulses", np, 8);

    // R2 R3 R4 table walk
    for (int v = 0; v < NVEC; v++) begin
      wr(8'h48, 32'(VEC_CODE[v]));
      repeat (300) @(negedge clk);
      sync_pulse();
      count_win(WIN, np, nh);
      check(v == 0 ? "R2 pulses" : "R3 pulses", np, WIN / VEC_RATIO[v]);
      check(v == 0 ? "R2 high" : "R4 high", nh, v == 0 ? WIN : WIN / 2);
    end

    // R9 change only at period end: /256 active, switch to bypass mid-period
    sync_pulse();
    np = 0;
    for (int i = 1; i < 256; i++) begin
      @(negedge clk);
      if (div_pulse) np++;
      if (i == 10) begin reg_we = 1'b1; reg_wdata = 32'h0; end
      if (i == 11) reg_we = 1'b0;
    end
    check("R9 old period kept", np, 0);
    @(negedge clk);
    check("R9 period end pulse", int'(div_pulse), 1);
    count_win(16, np, nh);
    check("R9 new ratio", np, 16);

    // R7 reserved bits
    wr(8'h48, 32'hFFFF_FF02);
    rd(8'h48, d);
    check("R7 readback", int'(d), 32'h2);
    check("R7 no err", int'(code_err), 0);

    // R8 other offset
    wr(8'h4C, 32'h1);
    rd(8'h48, d);
    check("R8 unchanged", int'(d), 32'h2);
    rd(8'h4C, d);
    check("R8 other read", int'(d), 0);
    repeat (300) @(negedge clk);
    sync_pulse();
    count_win(WIN, np, nh);
    check("R8 ratio still /4", np, WIN / 4);

    // R5 invalid code
    wr(8'h48, 32'h3);
    rd(8'h48, d);
    check("R5 readback", int'(d), 3);
    check("R5 err", int'(code_err), 1);
    repeat (300) @(negedge clk);
    sync_pulse();
    count_win(WIN, np, nh);
    check("R5 ratio held", np, WIN / 4);

    // R6 sticky
    wr(8'h48, 32'h0);
    check("R6 err sticky", int'(code_err), 1);
    repeat (300) @(negedge clk);
    count_win(64, np, nh);
    check("R6 valid code still used", np, 64);

    // R10 source select
    wr(8'h48, 32'h1);
    repeat (300) @(negedge clk);
    sync_pulse();
    @(negedge clk);
    src_sel = 1'b1; bus_tick = 1'b0;
    @(negedge clk);
    dc0 = div_clk;
    np = 0; nh = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (div_pulse) np++;
      if (div_clk != dc0) nh++;
    end
    check("R10 silent source pulses", np, 0);
    check("R10 silent source clk", nh, 0);
    np = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (div_pulse) np++;
      bus_tick = ~bus_tick;
    end
    check("R10 bus ticks", np, 16);

    summary();
  end
endmodule